// File: doc/BRIEF.md
# Burst-of-Four Double-Rate SRAM Model

A synthesizable behavioural model of a small synchronous SRAM with one shared data bus, shown here as separate write-in and read-out ports. Every access moves four data words. One address and a read or write flag are taken per burst. Data moves twice per clock. The model holds this on a single clock by carrying a rise word and a fall word in each cycle. A burst holds the bus for two cycles, so a new command is taken at most every second cycle.

Write data follows its command by one cycle and is committed to the array late, once its last pair of words has arrived. Each word lane has its own enable. A read issued in the same cycle as that commit still sees the new data, because a bypass merges the pending write into the read. Read data comes out after a fixed latency, counted in half-cycle slots. In wide mode the two low address bits set the start of a wrapping word sequence. In narrow mode those bits are ignored and the lanes shrink to nibbles.

Top module: `sram_b4_ddr`

## Requirements
- R1: Every accepted read returns exactly four valid half-cycle slots, and no valid slot appears that does not belong to an accepted read.
- R2: In wide mode (NARROW=0), beat k of a burst at address A uses word {A[ADDR_W-1:2], (A[1:0]+k) mod 4}, so the sequence wraps from 3 to 0.
- R3: In narrow mode (NARROW=1), A[1:0] is ignored and beat k uses word {A[ADDR_W-1:2], k}.
- R4: Enable bit i writes data bits [i*LANE_W +: LANE_W] of its beat. LANE_W is 8 in wide mode and 4 in narrow mode. A lane whose enable is 0 keeps its old contents.
- R5: Write beats 0 and 1 arrive on wrRise/wrFall (with wrEnRise/wrEnFall) in the cycle after the write command. Beats 2 and 3 arrive in the cycle after that, which is when the array is updated.
- R6: For a read accepted in cycle c, beat k appears in half-slot 2c+RD_LAT_HALF+k, where half-slot 2n is the rise word of cycle n and 2n+1 is its fall word. The default RD_LAT_HALF is 3.
- R7: A read issued in the cycle when an earlier write to the same four-word block commits returns the merged new data.
- R8: A command presented in the cycle right after an accepted command is ignored. It produces no read data and does not change the array.
- R9: While reset is asserted, rdRiseValid and rdFallValid are 0.
- R10: Reads accepted every second cycle produce an unbroken stream of valid half-slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Burst command strobe |
| cmdRead | input | 1 | 1 = read burst, 0 = write burst |
| cmdAddr | input | ADDR_W | Word address of the burst |
| wrRise | input | DATA_W | Write word for the rising half of the cycle |
| wrFall | input | DATA_W | Write word for the falling half of the cycle |
| wrEnRise | input | LANES | Lane enables for wrRise |
| wrEnFall | input | LANES | Lane enables for wrFall |
| rdRise | output | DATA_W | Read word for the rising half |
| rdFall | output | DATA_W | Read word for the falling half |
| rdRiseValid | output | 1 | rdRise holds a read beat |
| rdFallValid | output | 1 | rdFall holds a read beat |

## Verification
Two instances, one wide and one narrow, receive the same stimulus. A reference model predicts the data and the half-slot of every beat. Start addresses cover all four low-bit values, which separates the wrapping sequence from the fixed one. Lane masks that are full, partial and empty separate byte masking from nibble masking. A read placed directly after a write to the same block separates a coherent bypass from a stale array read. Back-to-back reads show the output stream has no gaps, and commands placed in the blocked cycle show they are discarded.

// File: rtl/sram_b4_pkg.sv
package sram_b4_pkg;
  typedef struct packed {
    logic accept;
    logic isRead;
    logic capLo;
    logic commit;
    logic emitLo;
    logic emitHi;
  } b4Strobes_t;
endpackage

// File: rtl/b4_ctrl.sv
module b4_ctrl
  import sram_b4_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdRead,
  output b4Strobes_t strobes
);
  logic wrS1, wrS2, rdS1, rdS2;
  logic busy, accept;

  assign busy   = wrS1 | rdS1;
  assign accept = cmdValid & ~busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrS1 <= 1'b0;
      wrS2 <= 1'b0;
      rdS1 <= 1'b0;
      rdS2 <= 1'b0;
    end else begin
      wrS1 <= accept & ~cmdRead;
      wrS2 <= wrS1;
      rdS1 <= accept & cmdRead;
      rdS2 <= rdS1;
    end
  end

  always_comb begin
    strobes.accept = accept;
    strobes.isRead = cmdRead;
    strobes.capLo  = wrS1;
    strobes.commit = wrS2;
    strobes.emitLo = rdS1;
    strobes.emitHi = rdS2;
  end
endmodule

// File: rtl/b4_datapath.sv
module b4_datapath
  import sram_b4_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  parameter int NARROW = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  b4Strobes_t               strobes,
  input  logic [ADDR_W-1:0]        cmdAddr,
  input  logic [DATA_W-1:0]        wrRise,
  input  logic [DATA_W-1:0]        wrFall,
  input  logic [DATA_W/LANE_W-1:0] wrEnRise,
  input  logic [DATA_W/LANE_W-1:0] wrEnFall,
  output logic [DATA_W-1:0]        baseRise,
  output logic [DATA_W-1:0]        baseFall,
  output logic                     baseValid
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int BLK_W = ADDR_W - 2;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BEATS = 4;

  logic [DATA_W-1:0] mem [DEPTH];

  logic [BLK_W-1:0]  wrBlk;
  logic [1:0]        wrLsb;
  logic [DATA_W-1:0] loData [2];
  logic [LANES-1:0]  loEn   [2];
  logic [DATA_W-1:0] rdBuf  [BEATS];

  logic [DATA_W-1:0] beatData [BEATS];
  logic [LANES-1:0]  beatEn   [BEATS];
  logic [DATA_W-1:0] merged   [BEATS];
  logic [DATA_W-1:0] readWord [BEATS];

  logic [1:0]       cmdLsb;
  logic [BLK_W-1:0] cmdBlk;
  logic             wrHit;

  assign cmdBlk = cmdAddr[ADDR_W-1:2];
  assign wrHit  = strobes.commit && (cmdBlk == wrBlk);

  generate
    if (NARROW != 0) begin : g_narrow
      assign cmdLsb = 2'b00;
    end else begin : g_wide
      assign cmdLsb = cmdAddr[1:0];
    end
  endgenerate

  always_comb begin
    beatData[0] = loData[0];
    beatData[1] = loData[1];
    beatData[2] = wrRise;
    beatData[3] = wrFall;
    beatEn[0]   = loEn[0];
    beatEn[1]   = loEn[1];
    beatEn[2]   = wrEnRise;
    beatEn[3]   = wrEnFall;
  end

  // pending write folded over the current array contents, per word offset
  always_comb begin
    for (int o = 0; o < BEATS; o++) begin
      logic [1:0]        src;
      logic [DATA_W-1:0] oldWord;
      src     = 2'(o) - wrLsb;
      oldWord = mem[{wrBlk, 2'(o)}];
      for (int l = 0; l < LANES; l++) begin
        merged[o][l*LANE_W +: LANE_W] = beatEn[src][l] ?
          beatData[src][l*LANE_W +: LANE_W] : oldWord[l*LANE_W +: LANE_W];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < BEATS; k++) begin
      logic [1:0] rdOff;
      rdOff       = cmdLsb + 2'(k);
      readWord[k] = wrHit ? merged[rdOff] : mem[{cmdBlk, rdOff}];
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.commit) begin
      for (int o = 0; o < BEATS; o++) mem[{wrBlk, 2'(o)}] <= merged[o];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrBlk <= '0;
      wrLsb <= '0;
      for (int i = 0; i < 2; i++) begin
        loData[i] <= '0;
        loEn[i]   <= '0;
      end
      for (int k = 0; k < BEATS; k++) rdBuf[k] <= '0;
    end else begin
      if (strobes.accept && !strobes.isRead) begin
        wrBlk <= cmdBlk;
        wrLsb <= cmdLsb;
      end
      if (strobes.capLo) begin
        loData[0] <= wrRise;
        loData[1] <= wrFall;
        loEn[0]   <= wrEnRise;
        loEn[1]   <= wrEnFall;
      end
      if (strobes.accept && strobes.isRead) begin
        for (int k = 0; k < BEATS; k++) rdBuf[k] <= readWord[k];
      end
    end
  end

  assign baseValid = strobes.emitLo | strobes.emitHi;
  assign baseRise  = strobes.emitHi ? rdBuf[2] : rdBuf[0];
  assign baseFall  = strobes.emitHi ? rdBuf[3] : rdBuf[1];
endmodule

// File: rtl/b4_out_align.sv
module b4_out_align #(
  parameter int DATA_W      = 16,
  parameter int RD_LAT_HALF = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] baseRise,
  input  logic [DATA_W-1:0] baseFall,
  input  logic              baseValid,
  output logic [DATA_W-1:0] rdRise,
  output logic [DATA_W-1:0] rdFall,
  output logic              rdRiseValid,
  output logic              rdFallValid
);
  localparam int FULL = (RD_LAT_HALF - 2) / 2;
  localparam int HALF = (RD_LAT_HALF - 2) % 2;

  logic [DATA_W-1:0] dRise, dFall;
  logic              dValid;

  generate
    if (FULL == 0) begin : g_nodelay
      assign dRise  = baseRise;
      assign dFall  = baseFall;
      assign dValid = baseValid;
    end else begin : g_delay
      logic [DATA_W-1:0] pipeR [FULL];
      logic [DATA_W-1:0] pipeF [FULL];
      logic              pipeV [FULL];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < FULL; i++) begin
            pipeR[i] <= '0;
            pipeF[i] <= '0;
            pipeV[i] <= 1'b0;
          end
        end else begin
          pipeR[0] <= baseRise;
          pipeF[0] <= baseFall;
          pipeV[0] <= baseValid;
          for (int i = 1; i < FULL; i++) begin
            pipeR[i] <= pipeR[i-1];
            pipeF[i] <= pipeF[i-1];
            pipeV[i] <= pipeV[i-1];
          end
        end
      end
      assign dRise  = pipeR[FULL-1];
      assign dFall  = pipeF[FULL-1];
      assign dValid = pipeV[FULL-1];
    end

    if (HALF == 1) begin : g_halfslot
      logic [DATA_W-1:0] heldFall;
      logic              heldValid;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          heldFall  <= '0;
          heldValid <= 1'b0;
        end else begin
          heldFall  <= dFall;
          heldValid <= dValid;
        end
      end
      assign rdRise      = heldFall;
      assign rdRiseValid = heldValid;
      assign rdFall      = dRise;
      assign rdFallValid = dValid;
    end else begin : g_aligned
      assign rdRise      = dRise;
      assign rdFall      = dFall;
      assign rdRiseValid = dValid;
      assign rdFallValid = dValid;
    end
  endgenerate
endmodule

// File: rtl/sram_b4_ddr.sv
module sram_b4_ddr
  import sram_b4_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int NARROW      = 0,
  parameter int RD_LAT_HALF = 3,
  localparam int LANE_W     = (NARROW != 0) ? 4 : 8,
  localparam int LANES      = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdRead,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] wrRise,
  input  logic [DATA_W-1:0] wrFall,
  input  logic [LANES-1:0]  wrEnRise,
  input  logic [LANES-1:0]  wrEnFall,
  output logic [DATA_W-1:0] rdRise,
  output logic [DATA_W-1:0] rdFall,
  output logic              rdRiseValid,
  output logic              rdFallValid
);
  b4Strobes_t        strobes;
  logic [DATA_W-1:0] baseRise, baseFall;
  logic              baseValid;

  b4_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdRead  (cmdRead),
    .strobes  (strobes)
  );

  b4_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANE_W (LANE_W),
    .NARROW (NARROW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cmdAddr   (cmdAddr),
    .wrRise    (wrRise),
    .wrFall    (wrFall),
    .wrEnRise  (wrEnRise),
    .wrEnFall  (wrEnFall),
    .baseRise  (baseRise),
    .baseFall  (baseFall),
    .baseValid (baseValid)
  );

  b4_out_align #(
    .DATA_W      (DATA_W),
    .RD_LAT_HALF (RD_LAT_HALF)
  ) u_align (
    .clk         (clk),
    .rstN        (rstN),
    .baseRise    (baseRise),
    .baseFall    (baseFall),
    .baseValid   (baseValid),
    .rdRise      (rdRise),
    .rdFall      (rdFall),
    .rdRiseValid (rdRiseValid),
    .rdFallValid (rdFallValid)
  );
endmodule

// File: rtl/sram_b4_checker.sv
module sram_b4_checker
  import sram_b4_pkg::*;
#(
  parameter int RD_LAT_HALF = 3
) (
  input logic       clk,
  input logic       rstN,
  input b4Strobes_t strobes,
  input logic       rdRiseValid,
  input logic       rdFallValid
);
  logic       rdAcc;
  logic [3:0] owed;

  assign rdAcc = strobes.accept & strobes.isRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) owed <= '0;
    else owed <= owed + (rdAcc ? 4'd4 : 4'd0) - 4'(rdRiseValid) - 4'(rdFallValid);
  end

  AST_BEATS_OWED: assert property (@(posedge clk) disable iff (!rstN)
    (rdRiseValid || rdFallValid) |-> (owed >= 4'(rdRiseValid) + 4'(rdFallValid))); // R1

  AST_OWED_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    owed <= 4'd8); // R1

  AST_CMD_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.accept) |-> !strobes.accept); // R8

  AST_WRITE_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> $past(strobes.accept && !strobes.isRead, 2)); // R5

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> (!rdRiseValid && !rdFallValid)); // R9

  generate
    if (RD_LAT_HALF % 2 == 1) begin : g_oddLat
      AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
        $past(rdAcc, RD_LAT_HALF / 2) |-> rdFallValid); // R6
    end else begin : g_evenLat
      AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
        $past(rdAcc, RD_LAT_HALF / 2) |-> rdRiseValid); // R6
    end
  endgenerate
endmodule

bind sram_b4_ddr sram_b4_checker #(.RD_LAT_HALF(RD_LAT_HALF)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .strobes     (strobes),
  .rdRiseValid (rdRiseValid),
  .rdFallValid (rdFallValid)
);

// File: tb/sram_b4_ddr_tb.sv
module sram_b4_ddr_tb;
  localparam int PERIOD = 10;
  localparam int RDL    = 3;
  localparam int NOPS   = 12;

  // {rd, addr[5:0], mask[3:0], seed[15:0]}
  localparam logic [26:0] OPS [NOPS] = '{
    {1'b0, 6'h05, 4'hF, 16'hA5A5},
    {1'b1, 6'h05, 4'h0, 16'h0000},
    {1'b0, 6'h0B, 4'h1, 16'h1234},
    {1'b1, 6'h08, 4'h0, 16'h0000},
    {1'b1, 6'h0B, 4'h0, 16'h0000},
    {1'b0, 6'h12, 4'h6, 16'hBEEF},
    {1'b0, 6'h12, 4'h9, 16'h0F0F},
    {1'b1, 6'h13, 4'h0, 16'h0000},
    {1'b1, 6'h22, 4'h0, 16'h0000},
    {1'b0, 6'h3F, 4'h0, 16'hFFFF},
    {1'b1, 6'h3C, 4'h0, 16'h0000},
    {1'b1, 6'h3E, 4'h0, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic        cmdValid = 1'b0, cmdRead = 1'b0;
  logic [5:0]  cmdAddr = '0;
  logic [15:0] wrRise = '0, wrFall = '0;
  logic [1:0]  enRiseW = '0, enFallW = '0;
  logic [3:0]  enRiseN = '0, enFallN = '0;
  logic [15:0] rdRiseW, rdFallW, rdRiseN, rdFallN;
  logic        rvW, fvW, rvN, fvN;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  logic [15:0] memW [64];
  logic [15:0] memN [64];
  logic [15:0] expWd[$], expNd[$];
  int          expWh[$], expNh[$];
  string       expWt[$], expNt[$];

  bit          pendValid = 0;
  logic [15:0] pendD2, pendD3;
  logic [3:0]  pendM;

  sram_b4_ddr u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRead(cmdRead), .cmdAddr(cmdAddr),
    .wrRise(wrRise), .wrFall(wrFall), .wrEnRise(enRiseW), .wrEnFall(enFallW),
    .rdRise(rdRiseW), .rdFall(rdFallW), .rdRiseValid(rvW), .rdFallValid(fvW)
  );

  sram_b4_ddr #(.NARROW(1)) u_dutNarrow (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRead(cmdRead), .cmdAddr(cmdAddr),
    .wrRise(wrRise), .wrFall(wrFall), .wrEnRise(enRiseN), .wrEnFall(enFallN),
    .rdRise(rdRiseN), .rdFall(rdFallN), .rdRiseValid(rvN), .rdFallValid(fvN)
  );

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] beatVal(input logic [15:0] seed, input int j);
    return 16'(seed + 16'h1357 * j);
  endfunction

  function automatic logic [15:0] mergeW(input logic [15:0] o, input logic [15:0] n, input logic [1:0] m);
    logic [15:0] r = o;
    for (int l = 0; l < 2; l++) if (m[l]) r[l*8 +: 8] = n[l*8 +: 8];
    return r;
  endfunction

  function automatic logic [15:0] mergeN(input logic [15:0] o, input logic [15:0] n, input logic [3:0] m);
    logic [15:0] r = o;
    for (int l = 0; l < 4; l++) if (m[l]) r[l*4 +: 4] = n[l*4 +: 4];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic gotBeat(input bit narrow, input logic [15:0] d, input int half);
    logic [15:0] ed;
    int          eh;
    string       et;
    if (narrow ? expNd.size() == 0 : expWd.size() == 0) begin
      check(0, narrow ? "R1 narrow unexpected beat" : "R1 wide unexpected beat", 32'(half), 32'hFFFFFFFF);
    end else begin
      if (narrow) begin ed = expNd.pop_front(); eh = expNh.pop_front(); et = expNt.pop_front(); end
      else        begin ed = expWd.pop_front(); eh = expWh.pop_front(); et = expWt.pop_front(); end
      check(d == ed, {et, " data"}, 32'(d), 32'(ed));
      check(half == eh, "R6/R10 half-slot", 32'(half), 32'(eh));
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (rvW) gotBeat(0, rdRiseW, 2*cyc);
      if (fvW) gotBeat(0, rdFallW, 2*cyc+1);
      if (rvN) gotBeat(1, rdRiseN, 2*cyc);
      if (fvN) gotBeat(1, rdFallN, 2*cyc+1);
    end
  end

  task automatic setEn(input logic [3:0] mr, input logic [3:0] mf);
    enRiseW = mr[1:0]; enFallW = mf[1:0];
    enRiseN = mr;      enFallN = mf;
  endtask

  // one accepted burst: command cycle, then the cycle in which new commands are blocked
  task automatic op(input bit rd, input logic [5:0] a, input logic [3:0] m, input logic [15:0] seed,
                    input string tag, input bit extra = 0, input bit exRd = 0, input logic [5:0] exA = '0);
    int c;
    @(negedge clk);
    cmdValid = 1'b1; cmdRead = rd; cmdAddr = a;
    if (pendValid) begin wrRise = pendD2; wrFall = pendD3; setEn(pendM, pendM); end
    else setEn(4'h0, 4'h0);
    pendValid = 0;
    c = cyc;
    for (int k = 0; k < 4; k++) begin
      logic [5:0] wa, na;
      wa = {a[5:2], 2'(a[1:0] + 2'(k))};
      na = {a[5:2], 2'(k)};
      if (rd) begin
        expWd.push_back(memW[wa]); expWh.push_back(2*c + RDL + k); expWt.push_back({tag, " R2 wide"});
        expNd.push_back(memN[na]); expNh.push_back(2*c + RDL + k); expNt.push_back({tag, " R3 narrow"});
      end else begin
        memW[wa] = mergeW(memW[wa], beatVal(seed, k), m[1:0]);
        memN[na] = mergeN(memN[na], beatVal(seed, k), m);
      end
    end
    @(negedge clk);
    cmdValid = extra; cmdRead = exRd; cmdAddr = exA;
    if (!rd) begin
      wrRise = beatVal(seed, 0); wrFall = beatVal(seed, 1); setEn(m, m);
      pendValid = 1; pendD2 = beatVal(seed, 2); pendD3 = beatVal(seed, 3); pendM = m;
    end else begin
      wrRise = 16'hDEAD; wrFall = 16'hDEAD; setEn(4'hF, 4'hF);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cmdValid = 1'b0;
    if (pendValid) begin wrRise = pendD2; wrFall = pendD3; setEn(pendM, pendM); end
    else setEn(4'h0, 4'h0);
    pendValid = 0;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1 rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!rvW && !fvW, "R9 wide valids in reset", {30'b0, rvW, fvW}, 0);
    check(!rvN && !fvN, "R9 narrow valids in reset", {30'b0, rvN, fvN}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!rvW && !fvW && !rvN && !fvN, "R9 valids after reset", {28'b0, rvW, fvW, rvN, fvN}, 0);

    // fill every block with full-lane writes (R4, R5)
    for (int b = 0; b < 16; b++) op(0, 6'(b*4 + (b % 4)), 4'hF, 16'(16'h0F00 + 16'h0111 * b), "init");
    // read back with every start offset (R2, R3); back-to-back reads cover R10
    for (int b = 0; b < 16; b++) op(1, 6'(b*4 + ((b + 1) % 4)), 4'h0, 16'h0, "R10 fill readback");

    // table of mixed operations: wrap, lane masks (R4), read right after write (R7)
    for (int i = 0; i < NOPS; i++) begin
      logic [26:0] e;
      e = OPS[i];
      op(e[26], e[25:20], e[19:16], e[15:0], "R7 R4 table");
    end

    // R8: write in the blocked cycle must not land, read in the blocked cycle must return nothing
    op(0, 6'h20, 4'hF, 16'h7777, "R8 host", 1'b1, 1'b0, 6'h24);
    op(1, 6'h24, 4'h0, 16'h0, "R8 untouched", 1'b1, 1'b1, 6'h28);
    op(1, 6'h21, 4'h0, 16'h0, "R8 host readback");
    // R7 with a partial mask straight into a read of the same block at a wrapped start
    op(0, 6'h2E, 4'h2, 16'hC3C3, "R7 partial");
    op(1, 6'h2D, 4'h0, 16'h0, "R7 partial");

    repeat (8) idle();
    check(expWd.size() == 0, "R1 wide all beats delivered", expWd.size(), 0);
    check(expNd.size() == 0, "R1 narrow all beats delivered", expNd.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule